// File: doc/BRIEF.md
# Accumulator Adjust and Flag Unit

This unit performs the five single-operand operations of an 8-bit CPU that act only on the accumulator and the flag byte: two's-complement negation, decimal (BCD) adjustment after an add or subtract, bitwise complement, forcing the carry and inverting the carry. It produces exact flag results. These include the two undocumented flag bits that mirror bits 5 and 3 of a result. The decimal adjust result depends on the value before adjustment and on the direction recorded by the subtract flag.

The caller presents the accumulator, the flag byte and a 3-bit operation code, and raises `start` for one cycle. On the next rising edge the updated accumulator and flags are registered at the outputs. At the same edge `done` pulses high for one cycle and `cost` reports the execution time of the operation in machine clock states. When no start is given, the outputs hold their last values. A start may be given on every cycle.

Top module: `acc_flag_unit`

## Requirements
- R1: While `rst_n` is low, `acc_out`, `flags_out` and `cost` are zero and `done` is low.
- R2: A cycle with `start` high registers the results and raises `done` for exactly the following cycle. A cycle with `start` low lowers `done` and leaves `acc_out`, `flags_out` and `cost` unchanged whatever the other inputs are.
- R3: Flag byte bit positions are: sign 7, zero 6, copy-of-bit-5 (Y) 5, half carry 4, copy-of-bit-3 (X) 3, parity/overflow 2, subtract 1, carry 0. Where an operation takes parity from a result, the parity bit is 1 when that result has an even number of one bits.
- R4: Op code 0 (negate) returns 0 minus A. Sign, zero, Y and X come from the result. Half carry is set when the low nibble of A is nonzero. Parity/overflow is set only when A was 0x80. Subtract is set. Carry is set when A was nonzero.
- R5: Op code 1 (decimal adjust) applies a low correction of 0x06 when half carry is set or A[3:0] exceeds 9. It applies a high correction of 0x60 when carry is set or A exceeds 0x99. The corrections are subtracted when the subtract flag is set and added when it is clear. Both corrections may apply at once.
- R6: After decimal adjust, subtract is kept and carry becomes old carry OR (A above 0x99). Half carry is bit 4 of (old A XOR result). Sign, zero, parity, Y and X come from the result.
- R7: Op code 2 (complement) inverts A and sets half carry and subtract. Y and X are copied from the new A. Sign, zero, parity and carry are kept.
- R8: Op code 3 (set carry) keeps A and sets carry. It clears half carry and subtract, copies A bits 5 and 3 into Y and X, and keeps sign, zero and parity.
- R9: Op code 4 (complement carry) keeps A, moves old carry into half carry, inverts carry and clears subtract. It copies A bits 5 and 3 into Y and X and keeps sign, zero and parity.
- R10: Op codes 5, 6 and 7 return A and the flag byte unchanged and still pulse `done`.
- R11: `cost` reads 8 after a negate and 4 after any other op code, including 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the current inputs |
| op | input | 3 | Operation code |
| acc_in | input | 8 | Accumulator value before the operation |
| flags_in | input | 8 | Flag byte before the operation |
| acc_out | output | 8 | Registered accumulator result |
| flags_out | output | 8 | Registered flag result |
| done | output | 1 | One-cycle pulse marking new results |
| cost | output | 4 | Clock states taken by the last operation |

## Verification
In a decimal adjust, the low-nibble correction and the high-nibble correction can both fire in the same operation. The combined 0x66 step then interacts with the carry out of the low nibble and with the half-carry result. The sweep provokes this by crossing every accumulator value with every combination of the subtract, half-carry and carry inputs. This covers values such as 0x9A and 0xFF and preset flags that force both fixes. The bench judges each case against an integer model that adds or subtracts the two corrections separately. Starts are issued back to back, so each result must also replace the previous one on the very next edge.

// File: rtl/aaf_pkg.sv
package aaf_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    OP_NEG = 3'd0,
    OP_DAA = 3'd1,
    OP_CPL = 3'd2,
    OP_SCF = 3'd3,
    OP_CCF = 3'd4
  } aaf_op_e;

  localparam int FL_S = 7;
  localparam int FL_Z = 6;
  localparam int FL_Y = 5;
  localparam int FL_H = 4;
  localparam int FL_X = 3;
  localparam int FL_P = 2;
  localparam int FL_N = 1;
  localparam int FL_C = 0;

  localparam byte_t LOW_FIX  = 8'h06;
  localparam byte_t HIGH_FIX = 8'h60;
  localparam byte_t BCD_MAX  = 8'h99;

  // R3: even number of ones gives 1
  function automatic logic even_ones(byte_t v);
    return ~(^v);
  endfunction

  // copy the two undocumented mirror bits from a value
  function automatic byte_t copy_yx(byte_t f, byte_t v);
    byte_t o;
    o       = f;
    o[FL_Y] = v[5];
    o[FL_X] = v[3];
    return o;
  endfunction

  // sign, zero, parity and mirror bits from a result
  function automatic byte_t result_flags(byte_t f, byte_t v);
    byte_t o;
    o       = copy_yx(f, v);
    o[FL_S] = v[BYTE_W-1];
    o[FL_Z] = (v == '0);
    o[FL_P] = even_ones(v);
    return o;
  endfunction
endpackage

// File: rtl/aaf_negate.sv
module aaf_negate
  import aaf_pkg::*;
(
  input  byte_t acc,
  input  byte_t flags,
  output byte_t res,
  output byte_t res_flags
);
  localparam byte_t MIN_NEG = byte_t'(1) << (BYTE_W - 1);

  always_comb begin
    res       = ~acc + byte_t'(1);
    res_flags = result_flags(flags, res);
    res_flags[FL_H] = (acc[3:0] != 4'h0);
    res_flags[FL_P] = (acc == MIN_NEG);
    res_flags[FL_N] = 1'b1;
    res_flags[FL_C] = (acc != '0);
  end
endmodule

// File: rtl/aaf_decimal_adjust.sv
module aaf_decimal_adjust
  import aaf_pkg::*;
(
  input  byte_t acc,
  input  byte_t flags,
  output byte_t res,
  output byte_t res_flags,
  output logic  lo_fix,
  output logic  hi_fix
);
  byte_t step;

  always_comb begin
    lo_fix = flags[FL_H] | (acc[3:0] > 4'd9);
    hi_fix = flags[FL_C] | (acc > BCD_MAX);
    step   = (lo_fix ? LOW_FIX : '0) | (hi_fix ? HIGH_FIX : '0);
    res    = flags[FL_N] ? (acc - step) : (acc + step);
    res_flags = result_flags(flags, res);
    res_flags[FL_C] = flags[FL_C] | (acc > BCD_MAX);
    res_flags[FL_H] = acc[4] ^ res[4];
  end
endmodule

// File: rtl/aaf_carry_ops.sv
module aaf_carry_ops
  import aaf_pkg::*;
(
  input  logic [2:0] op,
  input  byte_t      acc,
  input  byte_t      flags,
  output byte_t      res,
  output byte_t      res_flags
);
  always_comb begin
    res       = acc;
    res_flags = flags;
    unique case (op)
      OP_CPL: begin
        res       = ~acc;
        res_flags = copy_yx(flags, ~acc);
        res_flags[FL_H] = 1'b1;
        res_flags[FL_N] = 1'b1;
      end
      OP_SCF: begin
        res_flags = copy_yx(flags, acc);
        res_flags[FL_C] = 1'b1;
        res_flags[FL_H] = 1'b0;
        res_flags[FL_N] = 1'b0;
      end
      OP_CCF: begin
        res_flags = copy_yx(flags, acc);
        res_flags[FL_H] = flags[FL_C];
        res_flags[FL_C] = ~flags[FL_C];
        res_flags[FL_N] = 1'b0;
      end
      default: begin
        res       = acc;
        res_flags = flags;
      end
    endcase
  end
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
  import aaf_pkg::*;
#(
  parameter int unsigned COST_W    = 4,
  parameter int unsigned NEG_COST  = 8,
  parameter int unsigned BASE_COST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [7:0]        acc_in,
  input  logic [7:0]        flags_in,
  output logic [7:0]        acc_out,
  output logic [7:0]        flags_out,
  output logic              done,
  output logic [COST_W-1:0] cost
);
  localparam logic [COST_W-1:0] NEG_C  = COST_W'(NEG_COST);
  localparam logic [COST_W-1:0] BASE_C = COST_W'(BASE_COST);

  byte_t neg_acc, neg_flags;
  byte_t daa_acc, daa_flags;
  byte_t misc_acc, misc_flags;
  logic  daa_lo_fix, daa_hi_fix;
  byte_t nxt_acc, nxt_flags;
  logic [COST_W-1:0] nxt_cost;

  aaf_negate u_neg (
    .acc       (acc_in),
    .flags     (flags_in),
    .res       (neg_acc),
    .res_flags (neg_flags)
  );

  aaf_decimal_adjust u_daa (
    .acc       (acc_in),
    .flags     (flags_in),
    .res       (daa_acc),
    .res_flags (daa_flags),
    .lo_fix    (daa_lo_fix),
    .hi_fix    (daa_hi_fix)
  );

  aaf_carry_ops u_misc (
    .op        (op),
    .acc       (acc_in),
    .flags     (flags_in),
    .res       (misc_acc),
    .res_flags (misc_flags)
  );

  always_comb begin
    nxt_cost = BASE_C;
    unique case (op)
      OP_NEG: begin
        nxt_acc   = neg_acc;
        nxt_flags = neg_flags;
        nxt_cost  = NEG_C;
      end
      OP_DAA: begin
        nxt_acc   = daa_acc;
        nxt_flags = daa_flags;
      end
      default: begin
        nxt_acc   = misc_acc;
        nxt_flags = misc_flags;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_out   <= '0;
      flags_out <= '0;
      cost      <= '0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        acc_out   <= nxt_acc;
        flags_out <= nxt_flags;
        cost      <= nxt_cost;
      end
    end
  end
endmodule

// File: rtl/acc_flag_unit_chk.sv
module acc_flag_unit_chk
  import aaf_pkg::*;
#(
  parameter int unsigned COST_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [2:0]        op,
  input logic [7:0]        acc_in,
  input logic [7:0]        flags_in,
  input logic [7:0]        acc_out,
  input logic [7:0]        flags_out,
  input logic              done,
  input logic [COST_W-1:0] cost,
  input logic              daa_lo_fix,
  input logic              daa_hi_fix
);
  a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && $stable(acc_out) && $stable(flags_out) && $stable(cost)));

  a_r4_neg_sets_n: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_NEG) |=> flags_out[FL_N]);

  a_r5_both_fixes_add: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_DAA && daa_lo_fix && daa_hi_fix && !flags_in[FL_N])
      |=> acc_out == $past(acc_in) + 8'h66);

  a_r6_high_fix_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_DAA && daa_hi_fix) |=> flags_out[FL_C]);

  a_r8_scf_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_SCF) |=> (flags_out[FL_C] && !flags_out[FL_N] && !flags_out[FL_H]));

  a_r10_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op > 3'd4) |=> (acc_out == $past(acc_in) && flags_out == $past(flags_in)));

  a_r11_neg_cost: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == OP_NEG) |=> cost == COST_W'(8));
endmodule

bind acc_flag_unit acc_flag_unit_chk #(.COST_W(COST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .op         (op),
  .acc_in     (acc_in),
  .flags_in   (flags_in),
  .acc_out    (acc_out),
  .flags_out  (flags_out),
  .done       (done),
  .cost       (cost),
  .daa_lo_fix (daa_lo_fix),
  .daa_hi_fix (daa_hi_fix)
);

// File: tb/acc_flag_unit_tb.sv
module acc_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] flags_in = 8'h00;
  logic [7:0] acc_out, flags_out;
  logic       done;
  logic [3:0] cost;

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acc_flag_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .acc_in    (acc_in),
    .flags_in  (flags_in),
    .acc_out   (acc_out),
    .flags_out (flags_out),
    .done      (done),
    .cost      (cost)
  );

  // R3: parity by counting ones
  function automatic bit parity_even(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  function automatic void model(input int o, input int a, input int f,
                                output int ra, output int rf, output int rc);
    int fs = (f >> 7) & 1, fz = (f >> 6) & 1, fp = (f >> 2) & 1;
    int fh = (f >> 4) & 1, fn = (f >> 1) & 1, fc = f & 1;
    int s, z, y, h, x, p, n, c, r;
    s = fs; z = fz; p = fp; h = fh; n = fn; c = fc;
    r = a;
    rc = (o == 0) ? 8 : 4;                       // R11
    if (o >= 5) begin                            // R10
      ra = a; rf = f; return;
    end
    case (o)
      0: begin                                   // R4
        r = (256 - a) % 256;
        h = ((a % 16) != 0); p = (a == 128); n = 1; c = (a != 0);
        s = r / 128; z = (r == 0);
      end
      1: begin                                   // R5 R6
        int adj = 0;
        if (fh != 0 || (a % 16) > 9) adj += 6;
        if (fc != 0 || a > 153) adj += 96;
        r = (fn != 0) ? (a - adj + 256) % 256 : (a + adj) % 256;
        c = (fc != 0 || a > 153);
        h = (((a ^ r) >> 4) & 1);
        s = r / 128; z = (r == 0); p = parity_even(r);
      end
      2: begin r = 255 - a; h = 1; n = 1; end     // R7
      3: begin c = 1; h = 0; n = 0; end          // R8
      default: begin h = fc; c = 1 - fc; n = 0; end  // R9
    endcase
    y = (r >> 5) & 1; x = (r >> 3) & 1;
    ra = r;
    rf = s*128 + z*64 + y*32 + h*16 + x*8 + p*4 + n*2 + c;
  endfunction

  function automatic string tag_of(int o);
    case (o)
      0: return "R4";
      1: return "R3/R5/R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    int ea, ef, ec;
    logic [7:0] hold_a, hold_f;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (acc_out !== 8'h00 || flags_out !== 8'h00 || done !== 1'b0 || cost !== 4'd0) begin
      errors++;
      $display("FAIL R1 reset: acc=%h flags=%h done=%b cost=%0d expected 00 00 0 0",
               acc_out, flags_out, done, cost);
    end
    @(negedge clk);
    rst_n = 1'b1;

    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 8; k++) begin
        for (int a = 0; a < 256; a++) begin
          logic [7:0] av, fv;
          av = a[7:0];
          fv = {av[2] ^ av[7], av[5] ^ k[0], av[1], k[1], av[6], av[0] ^ av[3], k[2], k[0]};
          @(negedge clk);
          start = 1'b1; op = o[2:0]; acc_in = av; flags_in = fv;
          @(posedge clk);
          #1;
          model(o, a, int'(fv), ea, ef, ec);
          vectors++;
          if (acc_out !== ea[7:0] || flags_out !== ef[7:0] || done !== 1'b1) begin
            errors++;
            $display("FAIL %s op=%0d a=%h f=%h: got acc=%h flags=%h done=%b expected acc=%h flags=%h done=1",
                     tag_of(o), o, av, fv, acc_out, flags_out, done, ea[7:0], ef[7:0]);
          end
          vectors++;
          if (cost !== ec[3:0]) begin
            errors++;
            $display("FAIL R11 op=%0d: cost=%0d expected %0d", o, cost, ec);
          end
        end
      end
    end

    // R2: idle cycle with changed inputs must not disturb outputs
    hold_a = acc_out; hold_f = flags_out;
    @(negedge clk);
    start = 1'b0; op = 3'd2; acc_in = ~acc_in; flags_in = ~flags_in;
    @(posedge clk);
    #1;
    vectors++;
    if (done !== 1'b0 || acc_out !== hold_a || flags_out !== hold_f || cost !== 4'd4) begin
      errors++;
      $display("FAIL R2 idle: done=%b acc=%h flags=%h cost=%0d expected 0 %h %h 4",
               done, acc_out, flags_out, cost, hold_a, hold_f);
    end
    finished = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected end");
      summary();
    end
  end
endmodule